// File: doc/BRIEF.md
# Reuse-Gated Line Replication Controller

This block holds the per-line directory state that a shared last-level cache keeps at the bank owning a line. It decides whether a line earns a private replica in the bank cluster next to the requesting core. Each core has a saturating owner-reuse counter. The line as a whole has a copy-sharer vector with at most one bit set, a vector of cores holding the line in their private L1, and a replication indicator bit.

Events arrive one per cycle through a valid/ready handshake. Each event carries a kind, a core index, a reported replica-reuse value, a flag saying the owner bank lies in the requester's own cluster, and the reuse threshold to apply. A read hit advances the requester's counter and may produce a replicate command. A write produces an invalidation target vector. It then holds the block busy until one acknowledgement per target has arrived. Acknowledgements and replica evictions report replica reuse, which decides whether a copy sharer keeps its status.

The threshold is sampled with each event and may be any value from 1 to 8. Counters are 4 bits wide and stop at 15.

Top module: `repl_line_ctrl`

## Requirements
- R1: After reset the copy-sharer vector, the L1 holder vector, the replication indicator, busy and every owner-reuse counter are zero.
- R2: A read hit (kind 0) increments the requester's counter. When the incremented value is at least the threshold, the indicator is set. When, in addition, no core is a copy sharer and the owner is not local, `repl_valid_o` pulses for one cycle in the cycle after acceptance, `repl_core_o` names the requester, and the requester's bit is set in `copy_vec_o`.
- R3: Creating a replica sets the requester's counter to 1.
- R4: The threshold is taken from `thresh_i` at each accepted event. Values 1 to 8 place the replication on exactly that read hit, counting from a zero counter.
- R5: At most one core is a copy sharer. A core reaching the threshold while another core holds copy status gets no replica.
- R6: A read hit with `ev_local_i` high never produces a replica, even when the indicator is set.
- R7: A write (kind 1) pulses `inv_valid_o` in the cycle after acceptance when the target set is non-empty. `inv_vec_o` carries the L1 holders and copy sharers other than the writer. The holder vector then becomes the writer alone.
- R8: On a write, the writer's counter increments if the writer was the only holder (L1 or copy). Otherwise it is set to 1.
- R9: After a write with N targets, busy stays high until N acknowledgements (kind 2) have been accepted. While busy, only acknowledgements are accepted. When the last one is accepted, the counters of all cores except the writer are cleared. If there are no targets, they are cleared at the write itself.
- R10: An acknowledgement from a copy sharer keeps its copy status only if its counter plus the reported reuse exceeds the threshold. Otherwise its copy bit and the indicator clear. Any acknowledgement clears the sender's L1 holder bit.
- R11: A replica eviction (kind 3) from the copy sharer keeps copy status if the reported reuse is at least the threshold. Otherwise it demotes the sharer and clears the indicator.
- R12: Counters saturate at 15 rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid_i | input | 1 | Event offered |
| ev_ready_o | output | 1 | Event can be accepted |
| ev_kind_i | input | 2 | 0 read hit, 1 write, 2 invalidation ack, 3 replica eviction |
| ev_core_i | input | 3 | Core issuing the event |
| ev_reuse_i | input | 4 | Replica reuse reported with ack or eviction |
| ev_local_i | input | 1 | Owner bank is inside the requester's cluster |
| thresh_i | input | 4 | Reuse threshold, 1 to 8 |
| repl_valid_o | output | 1 | Replicate command pulse |
| repl_core_o | output | 3 | Core whose cluster receives the replica |
| inv_valid_o | output | 1 | Invalidation fan-out pulse |
| inv_vec_o | output | 8 | Cores to invalidate |
| copy_vec_o | output | 8 | Copy-sharer vector |
| sharer_vec_o | output | 8 | L1 holder vector |
| rib_o | output | 1 | Replication indicator |
| busy_o | output | 1 | Write waiting for acknowledgements |

## Verification
The hardest state to reach is a write that is still waiting for acknowledgements from both a copy sharer and plain holders, at the moment the copy sharer's ack arrives. The keep-or-demote decision then uses a counter that is about to be cleared. The stimulus builds that state by first driving one core over the threshold and having other cores read, and then writing from one of those readers. It sends the acks one at a time, tries a blocked read in between, and afterwards counts reads to expose the cleared counters. A long pseudo-random stream against an arithmetic reference model then covers the same situations with varying thresholds and reuse values.

// File: rtl/repl_pkg.sv
// Shared types for the line replication controller.
// Assumes a 2-bit event kind encoding fixed by the event source.
package repl_pkg;
    typedef enum logic [1:0] {
        EV_READ  = 2'd0,
        EV_WRITE = 2'd1,
        EV_ACK   = 2'd2,
        EV_EVICT = 2'd3
    } ev_kind_e;
endpackage

// File: rtl/repl_reuse_ctr.sv
// Saturating per-core owner-reuse counter.
// Priority: clear, then load of one, then increment. Assumes that at most
// one of these is requested per cycle by the owner, but resolves overlap anyway.
module repl_reuse_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             load_one_i,
    input  logic             clear_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // Counter update with saturation at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (clear_i)                    cnt_q <= '0;
        else if (load_one_i)                 cnt_q <= CNT_W'(1);
        else if (inc_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + CNT_W'(1);
    end

    assign cnt_o = cnt_q;

    p_no_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && inc_i && !clear_i && !load_one_i) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/repl_ack_tracker.sv
// Counts the invalidation acknowledgements still expected for a pending write.
// Assumes start_i is never raised while busy (the top holds off writes).
module repl_ack_tracker #(
    parameter int N_CORES = 8,
    localparam int TW     = $clog2(N_CORES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [TW-1:0] start_cnt_i,
    input  logic          ack_i,
    output logic          busy_o,
    output logic          done_o
);
    logic [TW-1:0] rem_q;

    // Load the expected count at a write, step down on each ack.
    always_ff @(posedge clk) begin
        if (!rst_n)                     rem_q <= '0;
        else if (start_i)               rem_q <= start_cnt_i;
        else if (ack_i && rem_q != '0)  rem_q <= rem_q - TW'(1);
    end

    assign busy_o = (rem_q != '0);
    assign done_o = (start_i && start_cnt_i == '0) || (ack_i && rem_q == TW'(1));

    p_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !ack_i && !start_i) |=> busy_o);
    p_ack_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ack_i && !start_i) |=> rem_q == $past(rem_q) - TW'(1));
endmodule

// File: rtl/repl_line_ctrl.sv
// Per-line replication decision logic at the owning bank.
// Tracks per-core saturating owner reuse, L1 holders, the single copy sharer
// and the replication indicator. Assumes the event source honours ev_ready_o
// and that cores named in an invalidation vector each acknowledge exactly once.
module repl_line_ctrl #(
    parameter int N_CORES    = 8,
    parameter int MAX_THRESH = 8,
    localparam int CORE_W    = $clog2(N_CORES),
    localparam int CNT_W     = $clog2(MAX_THRESH + 1),
    localparam int TW        = $clog2(N_CORES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_valid_i,
    output logic               ev_ready_o,
    input  logic [1:0]         ev_kind_i,
    input  logic [CORE_W-1:0]  ev_core_i,
    input  logic [CNT_W-1:0]   ev_reuse_i,
    input  logic               ev_local_i,
    input  logic [CNT_W-1:0]   thresh_i,
    output logic               repl_valid_o,
    output logic [CORE_W-1:0]  repl_core_o,
    output logic               inv_valid_o,
    output logic [N_CORES-1:0] inv_vec_o,
    output logic [N_CORES-1:0] copy_vec_o,
    output logic [N_CORES-1:0] sharer_vec_o,
    output logic               rib_o,
    output logic               busy_o
);
    import repl_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [N_CORES-1:0] copy_q, sharer_q;
    logic               rib_q;
    logic [CORE_W-1:0]  writer_q;
    logic [CNT_W-1:0]   cnt [N_CORES];

    logic               accept, is_rd, is_wr, is_ack, is_ev;
    logic [N_CORES-1:0] core_oh, others, clr_mask;
    logic [CNT_W-1:0]   cur_cnt, cnt_inc;
    logic [CNT_W:0]     reuse_sum;
    logic               hit_thr, do_repl, sole, ack_keep, ev_keep, demote;
    logic               trk_busy, trk_done;
    logic [TW-1:0]      tgt_cnt;

    // Event acceptance and decoding.
    always_comb begin
        ev_ready_o = !trk_busy || (ev_kind_i == EV_ACK);
        accept     = ev_valid_i && ev_ready_o;
        is_rd      = accept && (ev_kind_i == EV_READ);
        is_wr      = accept && (ev_kind_i == EV_WRITE);
        is_ack     = accept && (ev_kind_i == EV_ACK);
        is_ev      = accept && (ev_kind_i == EV_EVICT);
        core_oh    = N_CORES'(1) << ev_core_i;
    end

    // Threshold, sharing and keep-or-demote decisions for the current event.
    always_comb begin
        cur_cnt   = cnt[ev_core_i];
        cnt_inc   = (cur_cnt == CNT_MAX) ? cur_cnt : cur_cnt + CNT_W'(1);
        hit_thr   = (cnt_inc >= thresh_i);
        do_repl   = is_rd && hit_thr && !ev_local_i && (copy_q == '0);
        sole      = ((sharer_q | copy_q) == core_oh);
        others    = (sharer_q | copy_q) & ~core_oh;
        tgt_cnt   = TW'($countones(others));
        reuse_sum = {1'b0, cur_cnt} + {1'b0, ev_reuse_i};
        ack_keep  = (reuse_sum > {1'b0, thresh_i});
        ev_keep   = (ev_reuse_i >= thresh_i);
        demote    = copy_q[ev_core_i] && ((is_ack && !ack_keep) || (is_ev && !ev_keep));
        clr_mask  = is_wr ? ~core_oh : ~(N_CORES'(1) << writer_q);
    end

    repl_ack_tracker #(.N_CORES(N_CORES)) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (is_wr),
        .start_cnt_i (tgt_cnt),
        .ack_i       (is_ack),
        .busy_o      (trk_busy),
        .done_o      (trk_done)
    );

    for (genvar i = 0; i < N_CORES; i++) begin : g_ctr
        logic sel;
        assign sel = (ev_core_i == CORE_W'(i));
        repl_reuse_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk        (clk),
            .rst_n      (rst_n),
            .inc_i      ((is_rd && sel && !do_repl) || (is_wr && sel && sole)),
            .load_one_i ((do_repl && sel) || (is_wr && sel && !sole)),
            .clear_i    (trk_done && clr_mask[i]),
            .cnt_o      (cnt[i])
        );
    end

    // Copy-sharer vector and replication indicator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            copy_q <= '0;
            rib_q  <= 1'b0;
        end else begin
            if (do_repl)                copy_q <= copy_q | core_oh;
            else if (demote)            copy_q <= copy_q & ~core_oh;
            if (is_rd && hit_thr)       rib_q  <= 1'b1;
            else if (demote)            rib_q  <= 1'b0;
        end
    end

    // L1 holder vector and identity of the pending writer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sharer_q <= '0;
            writer_q <= '0;
        end else begin
            if (is_rd)       sharer_q <= sharer_q | core_oh;
            else if (is_wr)  sharer_q <= core_oh;
            else if (is_ack) sharer_q <= sharer_q & ~core_oh;
            if (is_wr)       writer_q <= ev_core_i;
        end
    end

    // Registered command pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            repl_valid_o <= 1'b0;
            repl_core_o  <= '0;
            inv_valid_o  <= 1'b0;
            inv_vec_o    <= '0;
        end else begin
            repl_valid_o <= do_repl;
            if (do_repl) repl_core_o <= ev_core_i;
            inv_valid_o  <= is_wr && (others != '0);
            inv_vec_o    <= is_wr ? others : '0;
        end
    end

    assign copy_vec_o   = copy_q;
    assign sharer_vec_o = sharer_q;
    assign rib_o        = rib_q;
    assign busy_o       = trk_busy;

    p_single_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(copy_q));
    p_copy_has_rib_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_q != '0) |-> rib_q);
    p_repl_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        repl_valid_o |-> copy_q[repl_core_o]);
    p_local_no_repl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ev_kind_i == EV_READ && ev_local_i) |=> !repl_valid_o);
    p_blocked_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (trk_busy && ev_valid_i && ev_kind_i == EV_READ) |=> ($stable(copy_q) && !repl_valid_o));
endmodule

// File: tb/repl_line_ctrl_tb_top.sv
module repl_line_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_valid = 1'b0;
    logic       ev_ready;
    logic [1:0] ev_kind = '0;
    logic [2:0] ev_core = '0;
    logic [3:0] ev_reuse = '0;
    logic       ev_local = 1'b0;
    logic [3:0] thr = 4'd4;
    logic       repl_valid, inv_valid, rib, busy;
    logic [2:0] repl_core;
    logic [7:0] inv_vec, copy_vec, sharer_vec;

    always #5 clk = ~clk;

    repl_line_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ev_valid_i(ev_valid), .ev_ready_o(ev_ready),
        .ev_kind_i(ev_kind), .ev_core_i(ev_core), .ev_reuse_i(ev_reuse),
        .ev_local_i(ev_local), .thresh_i(thr), .repl_valid_o(repl_valid),
        .repl_core_o(repl_core), .inv_valid_o(inv_valid), .inv_vec_o(inv_vec),
        .copy_vec_o(copy_vec), .sharer_vec_o(sharer_vec), .rib_o(rib), .busy_o(busy)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model state
    int       m_cnt [8];
    bit [7:0] m_copy, m_sh, m_pend;
    bit       m_rib;
    int       m_rem, m_wr;
    bit       e_repl, e_inv;
    int       e_rcore;
    bit [7:0] e_ivec;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_cnt[i] = 0;
        m_copy = '0; m_sh = '0; m_pend = '0; m_rib = 0; m_rem = 0; m_wr = 0;
        e_repl = 0; e_inv = 0; e_rcore = 0; e_ivec = '0;
    endtask

    task automatic model_apply(input int k, input int c, input int r,
                               input int l, input int t, input bit rdy);
        bit [7:0] oh, oth;
        int n;
        e_repl = 0; e_inv = 0; e_ivec = '0;
        if (!rdy) return;
        oh = 8'(1 << c);
        case (k)
            0: begin
                n = (m_cnt[c] == 15) ? 15 : m_cnt[c] + 1;
                if (n >= t) begin
                    m_rib = 1;
                    if (l == 0 && m_copy == 0) begin
                        m_copy = oh; m_cnt[c] = 1; e_repl = 1; e_rcore = c;
                    end else m_cnt[c] = n;
                end else m_cnt[c] = n;
                m_sh |= oh;
            end
            1: begin
                oth = (m_sh | m_copy) & ~oh;
                if ((m_sh | m_copy) == oh) m_cnt[c] = (m_cnt[c] == 15) ? 15 : m_cnt[c] + 1;
                else m_cnt[c] = 1;
                m_sh = oh; m_wr = c; m_pend = oth;
                m_rem = $countones(oth);
                e_inv = (oth != 0); e_ivec = oth;
                if (m_rem == 0) for (int i = 0; i < 8; i++) if (i != c) m_cnt[i] = 0;
            end
            2: begin
                if (m_copy[c] && !(m_cnt[c] + r > t)) begin m_copy = '0; m_rib = 0; end
                m_sh &= ~oh;
                m_pend &= ~oh;
                if (m_rem > 0) begin
                    m_rem--;
                    if (m_rem == 0) for (int i = 0; i < 8; i++) if (i != m_wr) m_cnt[i] = 0;
                end
            end
            default: begin
                if (m_copy[c] && r < t) begin m_copy = '0; m_rib = 0; end
            end
        endcase
    endtask

    // Called at a falling edge: drive, clock once, compare at next falling edge.
    task automatic ev(input int k, input int c, input int r, input int l,
                      input int t, input string tag);
        bit rdy;
        ev_kind = 2'(k); ev_core = 3'(c); ev_reuse = 4'(r);
        ev_local = l[0]; thr = 4'(t); ev_valid = 1'b1;
        rdy = (m_rem == 0) || (k == 2);
        #1;
        check(ev_ready == rdy, tag, "ready", int'(ev_ready), int'(rdy));
        model_apply(k, c, r, l, t, rdy);
        @(posedge clk);
        @(negedge clk);
        ev_valid = 1'b0;
        check(repl_valid == e_repl, tag, "repl_valid", int'(repl_valid), int'(e_repl));
        if (e_repl) check(int'(repl_core) == e_rcore, tag, "repl_core", int'(repl_core), e_rcore);
        check(inv_valid == e_inv, tag, "inv_valid", int'(inv_valid), int'(e_inv));
        check(inv_vec == e_ivec, tag, "inv_vec", int'(inv_vec), int'(e_ivec));
        check(copy_vec == m_copy, tag, "copy_vec", int'(copy_vec), int'(m_copy));
        check(sharer_vec == m_sh, tag, "sharer_vec", int'(sharer_vec), int'(m_sh));
        check(rib == m_rib, tag, "rib", int'(rib), int'(m_rib));
        check(busy == (m_rem > 0), tag, "busy", int'(busy), int'(m_rem > 0));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ev_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic reads(input int c, input int n, input int t, input string tag);
        for (int i = 0; i < n; i++) ev(0, c, 0, 0, t, tag);
    endtask

    task automatic run_all();
        bit [31:0] lf;
        // R1 reset state
        do_reset();
        check(copy_vec == 0 && sharer_vec == 0 && rib == 0 && busy == 0 && ev_ready == 1,
              "R1", "reset", int'({copy_vec, sharer_vec}), 0);

        // R2 / R4: replication lands on read number t, for every threshold
        for (int t = 1; t <= 8; t++) begin
            do_reset();
            for (int n = 1; n <= t; n++) begin
                ev(0, 5, 0, 0, t, "R4");
                check(repl_valid == (n == t), "R2", "repl at threshold", int'(repl_valid), int'(n == t));
            end
            check(copy_vec == 8'h20, "R4", "copy after threshold", int'(copy_vec), 32);
        end

        // R3 counter set to 1 after replication; R11 demote on low eviction reuse
        do_reset();
        reads(2, 3, 3, "R3");
        ev(3, 2, 0, 0, 3, "R11");
        check(copy_vec == 0 && rib == 0, "R11", "evict demote", int'(copy_vec), 0);
        ev(0, 2, 0, 0, 3, "R3");
        check(repl_valid == 0, "R3", "count 2 no repl", int'(repl_valid), 0);
        ev(0, 2, 0, 0, 3, "R3");
        check(repl_valid == 1, "R3", "count 3 repl", int'(repl_valid), 1);
        ev(3, 2, 3, 0, 3, "R11");
        check(copy_vec == 8'h04, "R11", "evict keep", int'(copy_vec), 4);

        // R5 single copy sharer
        do_reset();
        reads(0, 2, 2, "R5");
        reads(1, 2, 2, "R5");
        check(repl_valid == 0 && copy_vec == 8'h01, "R5", "second sharer blocked", int'(copy_vec), 1);

        // R6 local owner
        do_reset();
        for (int i = 0; i < 2; i++) ev(0, 4, 0, 1, 2, "R6");
        check(repl_valid == 0 && copy_vec == 0 && rib == 1, "R6", "local no replica",
              int'({rib, copy_vec}), 256);

        // R7..R10 write with pending acks
        do_reset();
        reads(1, 4, 4, "R7");
        ev(0, 2, 0, 0, 4, "R7");
        ev(0, 3, 0, 0, 4, "R7");
        ev(1, 2, 0, 0, 4, "R7");
        check(inv_valid == 1 && inv_vec == 8'h0A, "R7", "inv targets", int'(inv_vec), 10);
        check(sharer_vec == 8'h04, "R7", "holder is writer", int'(sharer_vec), 4);
        ev(0, 5, 0, 0, 4, "R9");
        check(busy == 1, "R9", "blocked read keeps busy", int'(busy), 1);
        ev(2, 3, 0, 0, 4, "R9");
        check(busy == 1, "R9", "one ack left", int'(busy), 1);
        ev(2, 1, 3, 0, 4, "R10");
        check(copy_vec == 0 && rib == 0 && busy == 0, "R10", "sum not above threshold demotes",
              int'(copy_vec), 0);
        reads(2, 3, 4, "R8");
        check(repl_valid == 1, "R8", "writer not sole set to 1", int'(repl_valid), 1);
        ev(3, 2, 0, 0, 4, "R11");
        reads(3, 3, 4, "R9");
        check(repl_valid == 0, "R9", "other counter cleared", int'(repl_valid), 0);
        ev(0, 3, 0, 0, 4, "R9");
        check(repl_valid == 1, "R9", "cleared counter reaches 4", int'(repl_valid), 1);

        // R8 sole writer increments
        do_reset();
        ev(0, 6, 0, 0, 4, "R8");
        ev(1, 6, 0, 0, 4, "R8");
        check(inv_valid == 0 && busy == 0, "R8", "no targets", int'(busy), 0);
        ev(0, 6, 0, 0, 4, "R8");
        check(repl_valid == 0, "R8", "count 3", int'(repl_valid), 0);
        ev(0, 6, 0, 0, 4, "R8");
        check(repl_valid == 1, "R8", "count 4 repl", int'(repl_valid), 1);

        // R10 keep on ack
        do_reset();
        reads(1, 4, 4, "R10");
        ev(1, 0, 0, 0, 4, "R10");
        ev(2, 1, 4, 0, 4, "R10");
        check(copy_vec == 8'h02, "R10", "sum above threshold keeps", int'(copy_vec), 2);

        // R12 saturation
        do_reset();
        reads(0, 8, 8, "R12");
        reads(1, 16, 8, "R12");
        ev(3, 0, 0, 0, 8, "R12");
        ev(0, 1, 0, 0, 8, "R12");
        check(repl_valid == 1, "R12", "saturated counter replicates", int'(repl_valid), 1);

        // Pseudo-random sweep against the model
        lf = 32'h1ACE_B00C;
        for (int i = 0; i < 4000; i++) begin
            int k, c, r, l, t;
            if (i % 500 == 0) do_reset();
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            c = int'(lf[2:0]); r = int'(lf[7:4]); l = (lf[10:8] == 0) ? 1 : 0;
            t = int'(lf[13:11]) + 1;
            if (m_rem > 0) begin
                if (lf[16:14] == 0) k = 0;
                else begin
                    k = 2;
                    for (int j = 7; j >= 0; j--) if (m_pend[j]) c = j;
                end
            end else begin
                case (lf[19:17])
                    3'd4: k = 1;
                    3'd5: k = 2;
                    3'd6: k = 3;
                    default: k = 0;
                endcase
            end
            ev(k, c, r, l, t, "MODEL");
        end
    endtask

    initial begin
        @(negedge clk);
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule